// File: doc/BRIEF.md
# Serial Flash Instruction Sequencer

The sequencer carries out one serial flash transaction at a time from a small table of programmed instruction sequences. Each sequence holds eight 16-bit instructions packed two to a 32-bit word. An instruction gives an opcode, a lane code that selects one, two or four IO lines, and an 8-bit operand. The host loads the table, writes a start command that names a sequence and a data byte count, and then waits for the done flag.

From the start command onwards the engine lowers chip select, steps through the sequence and runs each instruction for the number of serial clock cycles it needs. It shifts out command and mode bytes, counts dummy cycles, and moves data bytes between the serial lines and two byte FIFOs: a transmit FIFO that the host fills and a receive FIFO that the host drains. When the sequence ends, the engine raises chip select and sets a sticky done flag. An interrupt enable can route that flag to the interrupt output.

Top module: `sfseq_top`

## Requirements
- R1: An instruction holds its opcode in bits 15:10, its lane code in bits 9:8 and its operand in bits 7:0. Sequence s occupies table words 4*s to 4*s+3, and word k holds slot 2k in bits 15:0 and slot 2k+1 in bits 31:16. Slots execute in the order 0 to 7.
- R2: A write of `cmd_wdata` while idle starts a transaction: bits 31:24 give the sequence id and the low CNT_W bits give the data byte count. `busy` is 1 from the next cycle until chip select rises again. A start write while busy is ignored.
- R3: `cs_n` goes low one cycle before slot 0 begins and rises one cycle after the cycle in which the ending instruction is decoded. That ending cycle has no clock. While idle, `cs_n`=1 and `sclk_en`=0.
- R4: Opcodes 1 (command) and 4 (mode) send the operand MSB first in 8/L clocked cycles, where the lane code 0, 1 or 2 means L = 1, 2 or 4 lines. The data goes on io[0] for one line, on io[1:0] for two lines (io[1] carries the higher bit) and on io[3:0] for four lines. `io_oe` is set on exactly those lines, and every `io_out` bit that is not driven reads 0. Lane code 3 acts as four lines.
- R5: Opcode 12 (dummy) gives as many clocked cycles as its operand says, with all lines released. An operand above 64 counts as 64.
- R6: Opcode 7 (read) takes count*8/L clocked cycles with all lines released. It samples io[1] on one line and io[L-1:0] on two or four lines, MSB first. Each completed byte enters the receive FIFO in order.
- R7: Opcode 8 (write) sends count bytes from the transmit FIFO, MSB first, on the lines selected as in R4. If the FIFO is empty when a byte is due, that byte is sent as 0x00.
- R8: The sequence ends on opcode 0 (stop), on opcode 9 (jump on chip select) or on any opcode not listed in R4 to R7. It also ends after slot 7 has completed.
- R9: A read or write with a data count of 0, or a dummy with operand 0, takes one cycle with no clock and no driven lines.
- R10: `done` becomes 1 on the edge where chip select rises. It stays 1 until `done_clr` is pulsed. `irq` = `done` AND `irq_en`.
- R11: `tx_full` and `rx_empty` report the FIFO levels. A push into a full FIFO and a pop from an empty FIFO are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | SEQ_W+2 | Table word index |
| tbl_wdata | input | 32 | Two packed instructions |
| cmd_we | input | 1 | Start command strobe |
| cmd_wdata | input | 32 | Sequence id in 31:24, byte count in low bits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky transaction-finished flag |
| done_clr | input | 1 | Clears `done` (write-1-to-clear) |
| irq_en | input | 1 | Routes `done` to `irq` |
| irq | output | 1 | Interrupt request |
| tx_push | input | 1 | Transmit FIFO push |
| tx_wdata | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Receive FIFO pop |
| rx_rdata | output | 8 | Receive FIFO head byte |
| rx_empty | output | 1 | Receive FIFO empty |
| cs_n | output | 1 | Chip select, active low |
| sclk_en | output | 1 | Serial clock enable for this cycle |
| io_out | output | 4 | IO line output values |
| io_oe | output | 4 | IO line output enables |
| io_in | input | 4 | IO line input values |

## Verification
The bench builds the block with four sequences, an 8-bit byte count, a four-entry transmit FIFO and an eight-entry receive FIFO. The small transmit depth lets a five-byte write both fill the FIFO and drop a push, and then run into an empty-FIFO byte in the same transaction. With a short count width, every data phase stays a few dozen cycles long, so the cycle-by-cycle reference can cover command, mode, dummy, read and write phases on all three lane widths. It also covers the 64-cycle dummy cap and the eight-slot end within a short run.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;
   localparam int SLOTS      = 8;
   localparam int SEQ_WORDS  = 4;
   localparam int DUMMY_MAX  = 64;

   localparam logic [5:0] OPC_STOP  = 6'd0;
   localparam logic [5:0] OPC_SEND  = 6'd1;
   localparam logic [5:0] OPC_MODE  = 6'd4;
   localparam logic [5:0] OPC_READ  = 6'd7;
   localparam logic [5:0] OPC_WRITE = 6'd8;
   localparam logic [5:0] OPC_JUMP  = 6'd9;
   localparam logic [5:0] OPC_DUMMY = 6'd12;

   typedef enum logic [2:0] {IC_END, IC_SEND, IC_DUMMY, IC_READ, IC_WRITE} iclass_t;
   typedef enum logic [1:0] {ST_IDLE, ST_CSON, ST_EXEC} state_t;

   typedef struct packed {
      logic [5:0] opc;
      logic [1:0] lane;
      logic [7:0] arg;
   } instr_t;
endpackage

// File: rtl/sfseq_table.sv
module sfseq_table import sfseq_pkg::*; #(
   parameter int NUM_SEQ = 4,
   parameter int SEQ_W   = 2,
   parameter int ADDR_W  = SEQ_W + 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [SEQ_W-1:0]  rd_seq,
   input  logic [2:0]        rd_slot,
   output instr_t            rd_instr
);
   localparam int NWORDS = NUM_SEQ * SEQ_WORDS;

   logic [31:0] words [NWORDS];
   logic [ADDR_W-1:0] rd_idx;
   logic [31:0] rd_word;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[w] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(w))
            words[w] <= wr_data;
      end
   end

   assign rd_idx = {rd_seq, rd_slot[2:1]};

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < NWORDS; w++)
         if (rd_idx == ADDR_W'(w)) rd_word = words[w];
   end

   assign rd_instr = rd_slot[0] ? rd_word[31:16] : rd_word[15:0];
endmodule

// File: rtl/sfseq_decode.sv
module sfseq_decode import sfseq_pkg::*; #(
   parameter int CNT_W = 8,
   parameter int LEN_W = CNT_W + 3
)(
   input  instr_t           ins,
   input  logic [CNT_W-1:0] nbytes,
   output iclass_t          cls,
   output logic [1:0]       lc,
   output logic [2:0]       gmask,
   output logic [3:0]       lmask,
   output logic [LEN_W-1:0] len
);
   always_comb begin
      lc = (ins.lane == 2'd3) ? 2'd2 : ins.lane;
      case (lc)
         2'd0:    begin gmask = 3'd7; lmask = 4'b0001; end
         2'd1:    begin gmask = 3'd3; lmask = 4'b0011; end
         default: begin gmask = 3'd1; lmask = 4'b1111; end
      endcase

      case (ins.opc)
         OPC_SEND, OPC_MODE: cls = IC_SEND;
         OPC_DUMMY:          cls = IC_DUMMY;
         OPC_READ:           cls = IC_READ;
         OPC_WRITE:          cls = IC_WRITE;
         default:            cls = IC_END;
      endcase

      case (cls)
         IC_SEND:  len = LEN_W'(gmask) + 1'b1;
         IC_DUMMY: len = (ins.arg > 8'(DUMMY_MAX)) ? LEN_W'(DUMMY_MAX) : LEN_W'(ins.arg);
         IC_READ, IC_WRITE: begin
            case (lc)
               2'd0:    len = LEN_W'(nbytes) << 3;
               2'd1:    len = LEN_W'(nbytes) << 2;
               default: len = LEN_W'(nbytes) << 1;
            endcase
         end
         default:  len = '0;
      endcase
   end
endmodule

// File: rtl/sfseq_fifo.sv
module sfseq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sfseq_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= bump(wp);
         if (do_pop)  rp <= bump(rp);
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> $stable(count));
   assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> $stable(count));
endmodule

// File: rtl/sfseq_top.sv
module sfseq_top import sfseq_pkg::*; #(
   parameter int NUM_SEQ  = 4,
   parameter int CNT_W    = 8,
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 16,
   localparam int SEQ_W   = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1,
   localparam int TADDR_W = SEQ_W + 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_we,
   input  logic [TADDR_W-1:0] tbl_addr,
   input  logic [31:0]        tbl_wdata,
   input  logic               cmd_we,
   input  logic [31:0]        cmd_wdata,
   output logic               busy,
   output logic               done,
   input  logic               done_clr,
   input  logic               irq_en,
   output logic               irq,
   input  logic               tx_push,
   input  logic [7:0]         tx_wdata,
   output logic               tx_full,
   input  logic               rx_pop,
   output logic [7:0]         rx_rdata,
   output logic               rx_empty,
   output logic               cs_n,
   output logic               sclk_en,
   output logic [3:0]         io_out,
   output logic [3:0]         io_oe,
   input  logic [3:0]         io_in
);
   localparam int LEN_W = CNT_W + 3;

   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
      $error("sfseq_top: CNT_W must lie in 1..24");
   end
   if (NUM_SEQ < 1 || NUM_SEQ > 256) begin : g_bad_seq
      $error("sfseq_top: NUM_SEQ must lie in 1..256");
   end

   state_t           state;
   logic [3:0]       slot;
   logic [LEN_W-1:0] pos;
   logic [SEQ_W-1:0] seq_q;
   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       rx_sh;
   logic             done_q;

   instr_t           ins;
   iclass_t          cls, cls_eff;
   logic [1:0]       lc;
   logic [2:0]       gmask, grp, shamt;
   logic [3:0]       lmask, grp_bits;
   logic [LEN_W-1:0] len;
   logic             exec, len_zero, last_cyc, byte_last, active;
   logic             drive, rx_push, tx_pop, tx_empty, end_now;
   logic [7:0]       tx_head, src_byte, rx_next;

   sfseq_table #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W), .ADDR_W(TADDR_W)) i_table (
      .clk, .rst_n,
      .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
      .rd_seq(seq_q), .rd_slot(slot[2:0]), .rd_instr(ins)
   );

   sfseq_decode #(.CNT_W(CNT_W), .LEN_W(LEN_W)) i_decode (
      .ins, .nbytes(cnt_q), .cls, .lc, .gmask, .lmask, .len
   );

   sfseq_fifo #(.W(8), .DEPTH(TX_DEPTH)) i_txf (
      .clk, .rst_n, .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
      .rdata(tx_head), .full(tx_full), .empty(tx_empty)
   );

   sfseq_fifo #(.W(8), .DEPTH(RX_DEPTH)) i_rxf (
      .clk, .rst_n, .push(rx_push), .wdata(rx_next), .pop(rx_pop),
      .rdata(rx_rdata), .full(), .empty(rx_empty)
   );

   // Slot 8 is the implicit end after the last programmed slot.
   assign cls_eff   = slot[3] ? IC_END : cls;
   assign exec      = (state == ST_EXEC);
   assign end_now   = exec && (cls_eff == IC_END);
   assign len_zero  = (len == '0);
   assign last_cyc  = len_zero || (pos == len - 1'b1);
   assign active    = exec && (cls_eff != IC_END) && !len_zero;
   assign grp       = pos[2:0] & gmask;
   assign byte_last = (grp == gmask);
   assign shamt     = 3'((gmask - grp) << lc);

   assign src_byte  = (cls_eff == IC_WRITE) ? (tx_empty ? 8'h00 : tx_head) : ins.arg;
   assign grp_bits  = 4'(src_byte >> shamt) & lmask;
   assign drive     = active && ((cls_eff == IC_SEND) || (cls_eff == IC_WRITE));

   always_comb begin
      case (lc)
         2'd0:    rx_next = {rx_sh[6:0], io_in[1]};
         2'd1:    rx_next = {rx_sh[5:0], io_in[1:0]};
         default: rx_next = {rx_sh[3:0], io_in};
      endcase
   end

   assign rx_push = active && (cls_eff == IC_READ) && byte_last;
   assign tx_pop  = active && (cls_eff == IC_WRITE) && byte_last && !tx_empty;

   assign io_out  = drive ? grp_bits : 4'b0000;
   assign io_oe   = drive ? lmask : 4'b0000;
   assign sclk_en = active;
   assign cs_n    = (state == ST_IDLE);
   assign busy    = (state != ST_IDLE);
   assign done    = done_q;
   assign irq     = done_q & irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         slot  <= '0;
         pos   <= '0;
         seq_q <= '0;
         cnt_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (cmd_we) begin
               seq_q <= SEQ_W'(cmd_wdata[31:24]);
               cnt_q <= cmd_wdata[CNT_W-1:0];
               state <= ST_CSON;
            end
            ST_CSON: begin
               slot  <= '0;
               pos   <= '0;
               state <= ST_EXEC;
            end
            default: begin
               if (end_now) begin
                  state <= ST_IDLE;
               end else if (last_cyc) begin
                  slot <= slot + 1'b1;
                  pos  <= '0;
               end else begin
                  pos  <= pos + 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             rx_sh <= '0;
      else if (active && cls_eff == IC_READ)  rx_sh <= rx_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_q <= 1'b0;
      else if (end_now)  done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
   end

   assert_clock_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_en |-> !cs_n);
   assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_we) |=> ($stable(seq_q) && $stable(cnt_q)));
   assert_done_on_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   assert_lane_groups_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(io_oe) != 3);
   assert_dummy_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && cls_eff == IC_DUMMY) |-> (pos < LEN_W'(DUMMY_MAX)));
   assert_slot_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exec |-> (slot <= 4'd8));
   assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && cls_eff == IC_READ) |-> (io_oe == 4'b0000));
endmodule

// File: tb/test_sfseq_top.sv
`timescale 1ns/1ps
module test_sfseq_top;
   localparam int NSEQ = 4;
   localparam int TXD  = 4;
   localparam int RXD  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tbl_we = 0, cmd_we = 0, done_clr = 0, irq_en = 0, tx_push = 0, rx_pop = 0;
   logic [3:0]  tbl_addr = '0;
   logic [31:0] tbl_wdata = '0, cmd_wdata = '0;
   logic [7:0]  tx_wdata = '0;
   logic [3:0]  io_in = '0;
   logic busy, done, irq, tx_full, rx_empty, cs_n, sclk_en;
   logic [7:0] rx_rdata;
   logic [3:0] io_out, io_oe;

   always #2.5 clk = ~clk;

   sfseq_top #(.NUM_SEQ(NSEQ), .CNT_W(8), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_sfseq_top (
      .clk, .rst_n, .tbl_we, .tbl_addr, .tbl_wdata, .cmd_we, .cmd_wdata,
      .busy, .done, .done_clr, .irq_en, .irq, .tx_push, .tx_wdata, .tx_full,
      .rx_pop, .rx_rdata, .rx_empty, .cs_n, .sclk_en, .io_out, .io_oe, .io_in
   );

   int checks = 0, errors = 0;
   bit idle_watch = 0;
   logic [15:0] shadow [NSEQ][8];
   int txq[$], rxq[$], exp_q[$], din_q[$];
   string tag_q[$];
   int rnd = 5;

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] mk(input int op, input int lane, input int arg);
      return {6'(op), 2'(lane), 8'(arg)};
   endfunction

   // Idle cycles: chip select high, no clock, no driven lines (R3)
   always @(negedge clk) if (idle_watch)
      chk("R3", cs_n === 1'b1 && sclk_en === 1'b0 && io_oe === 4'b0,
          {cs_n, sclk_en, io_oe}, 6'b100000);

   task automatic load_seq(input int s);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         tbl_we = 1; tbl_addr = 4'(s*4 + k);
         tbl_wdata = {shadow[s][2*k+1], shadow[s][2*k]};
      end
      @(negedge clk); tbl_we = 0;
   endtask

   task automatic push_tx(input int b);
      @(negedge clk);
      tx_push = 1; tx_wdata = 8'(b);
      if (txq.size() < TXD) txq.push_back(b);
      @(negedge clk); tx_push = 0;
   endtask

   function automatic void add(input string tag, input int clkb, input int oe,
                               input int out, input int din);
      exp_q.push_back((1 << 10) | (clkb << 8) | (oe << 4) | out);
      din_q.push_back(din);
      tag_q.push_back(tag);
   endfunction

   task automatic run_txn(input int s, input int count, input bit poke);
      int act;
      exp_q.delete(); din_q.delete(); tag_q.delete();
      add("R3", 0, 0, 0, 0);
      for (int sl = 0; sl < 8; sl++) begin
         int op, lc, L, arg, mask, n;
         bit stop;
         string tg;
         op = shadow[s][sl][15:10]; lc = shadow[s][sl][9:8];
         if (lc == 3) lc = 2;
         L = 1 << lc; arg = shadow[s][sl][7:0]; mask = (1 << L) - 1;
         stop = 0;
         if (op == 1 || op == 4) begin
            tg = (sl % 2) ? "R1" : "R4";
            for (int g = 0; g < 8 / L; g++)
               add(tg, 1, mask, (arg >> (8 - L*(g+1))) & mask, 0);
         end else if (op == 12) begin
            n = (arg > 64) ? 64 : arg;
            if (n == 0) add("R9", 0, 0, 0, 0);
            for (int c = 0; c < n; c++) add("R5", 1, 0, 0, 0);
         end else if (op == 7) begin
            if (count == 0) add("R9", 0, 0, 0, 0);
            for (int b = 0; b < count; b++) begin
               int byt = 0;
               for (int g = 0; g < 8 / L; g++) begin
                  int din, bits;
                  rnd = (rnd * 5 + 3) % 16; din = rnd;
                  bits = (lc == 0) ? ((din >> 1) & 1) : (din & mask);
                  byt = ((byt << L) | bits) & 255;
                  add("R6", 1, 0, 0, din);
               end
               rxq.push_back(byt);
            end
         end else if (op == 8) begin
            if (count == 0) add("R9", 0, 0, 0, 0);
            for (int b = 0; b < count; b++) begin
               int byt;
               byt = (txq.size() > 0) ? txq.pop_front() : 0;
               for (int g = 0; g < 8 / L; g++)
                  add("R7", 1, mask, (byt >> (8 - L*(g+1))) & mask, 0);
            end
         end else stop = 1;
         if (stop) break;
      end
      add("R8", 0, 0, 0, 0);

      idle_watch = 0;
      @(negedge clk);
      cmd_we = 1; cmd_wdata = {8'(s), 16'h0, 8'(count)};
      @(negedge clk);
      cmd_we = 0;
      for (int i = 0; i < exp_q.size(); i++) begin
         act = {busy, cs_n, sclk_en, io_oe, io_out};
         chk(tag_q[i], act == exp_q[i], act, exp_q[i]);
         io_in = 4'(din_q[i]);
         cmd_we = 0;
         if (poke && i == 2) begin
            cmd_we = 1; cmd_wdata = {8'((s + 1) % NSEQ), 16'h0, 8'd9};  // R2: ignored while busy
         end
         @(negedge clk);
      end
      cmd_we = 0;
      chk("R3", cs_n === 1'b1 && busy === 1'b0, {cs_n, busy}, 2'b10);
      chk("R10", done === 1'b1, done, 1);
      idle_watch = 1;
   endtask

   task automatic drain_rx(input string tag);
      while (rxq.size() > 0) begin
         int e = rxq.pop_front();
         chk(tag, rx_empty === 1'b0 && rx_rdata == 8'(e), rx_rdata, e);
         rx_pop = 1; @(negedge clk); rx_pop = 0;
      end
      chk("R11", rx_empty === 1'b1, rx_empty, 1);
   endtask

   initial begin
      #(5.0 * 150000);
      chk("watchdog", 0, 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int s = 0; s < NSEQ; s++)
         for (int k = 0; k < 8; k++) shadow[s][k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R2", busy === 1'b0, busy, 0);
      chk("R3", cs_n === 1'b1 && sclk_en === 1'b0, {cs_n, sclk_en}, 2'b10);
      chk("R10", done === 1'b0 && irq === 1'b0, {done, irq}, 0);
      chk("R11", rx_empty === 1'b1 && tx_full === 1'b0, {rx_empty, tx_full}, 2'b10);
      idle_watch = 1;

      // R4/R6: single-line command then quad read of 3 bytes
      shadow[0][0] = mk(1, 0, 8'h9F);
      shadow[0][1] = mk(7, 2, 0);
      load_seq(0);
      run_txn(0, 3, 0);
      drain_rx("R6");

      // R10: interrupt routing and clear
      chk("R10", irq === 1'b0, irq, 0);
      irq_en = 1; #0.1;
      chk("R10", irq === 1'b1, irq, 1);
      done_clr = 1; @(negedge clk); done_clr = 0;
      chk("R10", done === 1'b0 && irq === 1'b0, {done, irq}, 0);
      irq_en = 0;

      // R1/R4/R5/R6: dual address bytes, quad dummy, dual read; R2 start while busy
      shadow[1][0] = mk(1, 0, 8'h6B);
      shadow[1][1] = mk(4, 1, 8'h12);
      shadow[1][2] = mk(4, 1, 8'h34);
      shadow[1][3] = mk(4, 3, 8'h56);
      shadow[1][4] = mk(12, 2, 8);
      shadow[1][5] = mk(7, 1, 0);
      load_seq(1);
      run_txn(1, 2, 1);
      drain_rx("R6");

      // R7/R11: quad write of 5 bytes with a 4-deep FIFO
      shadow[2][0] = mk(1, 0, 8'h32);
      shadow[2][1] = mk(4, 2, 8'hA5);
      shadow[2][2] = mk(8, 2, 0);
      load_seq(2);
      for (int b = 0; b < 4; b++) push_tx(8'hC3 + b * 8'h11);
      chk("R11", tx_full === 1'b1, tx_full, 1);
      push_tx(8'h77);
      run_txn(2, 5, 0);
      chk("R11", tx_full === 1'b0, tx_full, 0);

      // R5/R8/R9: dummy capped at 64, zero-count read, eight slots without stop
      shadow[3][0] = mk(12, 0, 200);
      shadow[3][1] = mk(7, 0, 0);
      shadow[3][2] = mk(1, 0, 8'h81);
      shadow[3][3] = mk(1, 1, 8'h3C);
      shadow[3][4] = mk(4, 2, 8'hE7);
      shadow[3][5] = mk(12, 1, 0);
      shadow[3][6] = mk(1, 0, 8'h01);
      shadow[3][7] = mk(4, 1, 8'hF0);
      load_seq(3);
      run_txn(3, 0, 0);
      chk("R9", rx_empty === 1'b1, rx_empty, 1);

      // R8: jump opcode ends the sequence early
      shadow[1][1] = mk(9, 0, 0);
      load_seq(1);
      run_txn(1, 2, 0);

      // R8: undefined opcode ends the sequence
      shadow[0][1] = mk(5, 0, 8'hFF);
      load_seq(0);
      run_txn(0, 3, 0);
      chk("R8", rx_empty === 1'b1, rx_empty, 1);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule